// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counter Timer

This block is a single timer channel behind a small register bus. The system clock first passes through an 8-bit programmable prescaler. A second stage then applies a selectable power-of-two divider. The two stages together produce a one-cycle tick enable in the system clock domain, and each tick steps a 16-bit down counter. No derived clock is produced.

Software never writes the counter directly. It writes a buffer register, and the counter takes the buffer value in one of two ways:
- a manual-update control bit, which loads the buffer on every cycle while the bit is set;
- an auto-reload option, which loads the buffer on the tick where the count is already zero.

A one-cycle wrap pulse marks each such underflow.

A typical free-running timebase is set up in four steps:
1. Write 0xFFFF to the buffer.
2. Write manual update together with auto-reload.
3. Write auto-reload alone.
4. Write start together with auto-reload.

The count can be read back at any time through the observation register.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, every register reads 0, the live count is 0 and `wrap_pulse` is low.
- R2: The register map and read-back are as follows. Unused bits read 0, and writes to 0x40 have no effect.

  | Offset | Contents |
  |---|---|
  | 0x00 | prescale value in bits [15:8] |
  | 0x04 | divider select in bits [19:16] |
  | 0x08 | start (bit 20), manual update (bit 21), auto-reload (bit 22) |
  | 0x3C | buffer in bits [15:0] |
  | 0x40 | live count in bits [15:0], read-only |
- R3: While counting, a tick occurs once every (P+1)·2^(S+1) cycles. P is the prescale value. S is the divider select, where codes 0, 1, 2 and 3 give /2, /4, /8 and /16, and any other code acts as 3. The first tick comes that many cycles after the start bit is written.
- R4: While manual update is set, the counter takes the buffer value on every cycle and does not decrement.
- R5: On each tick, with start set and manual update clear, a non-zero count decreases by exactly 1.
- R6: On a tick at count 0 with auto-reload set, the counter loads the buffer value and `wrap_pulse` is raised.
- R7: On a tick at count 0 with auto-reload clear:
  - the counter stays at 0;
  - `wrap_pulse` is raised only on the first such tick;
  - the pulse is not raised again until a manual update has loaded the counter.
- R8: `wrap_pulse` is high for exactly one cycle. That cycle is the one in which the count first shows its post-underflow value.
- R9: A buffer write changes the count only at the next load. A buffer write that lands on the same edge as a reload leaves the old buffer value in the counter.
- R10: With start clear, the count holds its value. Setting start again restarts the prescale path from zero, so the first tick comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wrap_pulse | output | 1 | One-cycle underflow indication |

## Verification
Two events can fall on the same clock edge: a software write of the buffer register and a reload of the counter on underflow. The bench provokes this collision with the fastest tick rate and a buffer value of 1. It times the bus write so that the write edge is exactly the underflow edge. The expected result is that the count shows the old buffer value and the pulse is raised. The new buffer value must then appear only at the following underflow, two ticks later, which the bench predicts from the tick period.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam int PRE_W    = 8;
  localparam int SEL_W    = 4;
  localparam int CNT_W    = 16;
  localparam int DIV_W    = 4;
  localparam int MAX_SEL  = 3;

  localparam logic [7:0] OFS_PRE  = 8'h00;
  localparam logic [7:0] OFS_DIV  = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_BUF  = 8'h3C;
  localparam logic [7:0] OFS_OBS  = 8'h40;

  localparam int PRE_LSB  = 8;
  localparam int SEL_LSB  = 16;
  localparam int BIT_RUN  = 20;
  localparam int BIT_MAN  = 21;
  localparam int BIT_AUTO = 22;

  typedef struct packed {
    logic auto_rl;
    logic man_upd;
    logic run;
  } ctl_t;

  function automatic logic [DIV_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    logic [DIV_W:0] span;
    int eff;
    eff  = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
    span = (DIV_W+1)'(1) << (eff + 1);
    return DIV_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/rdt_prescale.sv
module rdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PRE_W-1:0] pre_val,
  output logic             pre_tick
);
  logic [PRE_W-1:0] pc_q, pc_d;

  assign pre_tick = active && (pc_q == pre_val);

  always_comb begin
    pc_d = pc_q;
    if (!active)       pc_d = '0;
    else if (pre_tick) pc_d = '0;
    else               pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/rdt_divider.sv
module rdt_divider
  import rdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             pre_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] dc_q, dc_d;
  logic [DIV_W-1:0] lim;

  assign lim  = div_limit(sel);
  assign tick = active && pre_tick && (dc_q == lim);

  always_comb begin
    dc_d = dc_q;
    if (!active)       dc_d = '0;
    else if (tick)     dc_d = '0;
    else if (pre_tick) dc_d = dc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dc_q <= '0;
    else        dc_q <= dc_d;
  end
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             man_upd,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] bufv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             spent_q, spent_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    cnt_d   = cnt_q;
    spent_d = spent_q;
    wrap_d  = 1'b0;
    if (man_upd) begin
      cnt_d   = bufv;
      spent_d = 1'b0;
    end else if (active && tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (auto_rl) begin
        cnt_d   = bufv;
        wrap_d  = 1'b1;
        spent_d = 1'b0;
      end else if (!spent_q) begin
        wrap_d  = 1'b1;
        spent_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      spent_q <= spent_d;
      wrap_q  <= wrap_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = wrap_q;
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import rdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        wrap_pulse
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // register file
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] cnt;

  logic ctl_start, ctl_man, ctl_auto;
  assign ctl_start = ctl_q.run;
  assign ctl_man   = ctl_q.man_upd;
  assign ctl_auto  = ctl_q.auto_rl;

  always_comb begin
    pre_d = pre_q;
    sel_d = sel_q;
    ctl_d = ctl_q;
    buf_d = buf_q;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_PRE: pre_d = reg_wdata[PRE_LSB +: PRE_W];
        OFS_DIV: sel_d = reg_wdata[SEL_LSB +: SEL_W];
        OFS_CTL: ctl_d = '{auto_rl: reg_wdata[BIT_AUTO],
                           man_upd: reg_wdata[BIT_MAN],
                           run:     reg_wdata[BIT_RUN]};
        OFS_BUF: buf_d = reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pre_q <= '0;
      sel_q <= '0;
      ctl_q <= '0;
      buf_q <= '0;
    end else begin
      pre_q <= pre_d;
      sel_q <= sel_d;
      ctl_q <= ctl_d;
      buf_q <= buf_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[31:23], reg_wdata[7:0]};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_PRE: reg_rdata[PRE_LSB +: PRE_W] = pre_q;
      OFS_DIV: reg_rdata[SEL_LSB +: SEL_W] = sel_q;
      OFS_CTL: begin
        reg_rdata[BIT_RUN]  = ctl_q.run;
        reg_rdata[BIT_MAN]  = ctl_q.man_upd;
        reg_rdata[BIT_AUTO] = ctl_q.auto_rl;
      end
      OFS_BUF: reg_rdata[CNT_W-1:0] = buf_q;
      OFS_OBS: reg_rdata[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end

  // tick path
  logic counting;
  logic pre_tick;
  logic tick;

  assign counting = ctl_q.run && !ctl_q.man_upd;

  rdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (counting),
    .pre_val  (pre_q),
    .pre_tick (pre_tick)
  );

  rdt_divider u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (counting),
    .pre_tick (pre_tick),
    .sel      (sel_q),
    .tick     (tick)
  );

  rdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .active  (counting),
    .man_upd (ctl_q.man_upd),
    .auto_rl (ctl_q.auto_rl),
    .bufv    (buf_q),
    .cnt     (cnt),
    .wrap    (wrap_pulse)
  );
endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             man,
  input logic             auto_rl,
  input logic [CNT_W-1:0] bufv,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse
);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !man) |=> $stable(cnt));

  assert_manual_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    man |=> (cnt == $past(bufv)));

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_wrap_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ($past(cnt) == '0));

  assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(auto_rl)) |-> (cnt == $past(bufv)));

  assert_stop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !$past(auto_rl)) |-> (cnt == '0));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(man) && !pulse && (cnt != $past(cnt))) |-> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

bind reload_down_timer rdt_checker #(.CNT_W(rdt_pkg::CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (ctl_start),
  .man     (ctl_man),
  .auto_rl (ctl_auto),
  .bufv    (buf_q),
  .cnt     (cnt),
  .pulse   (wrap_pulse)
);

// File: tb/sim_reload_down_timer.sv
`timescale 1ns/1ps
module sim_reload_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h40;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wrap_pulse;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] C_RUN  = 32'h0010_0000;
  localparam logic [31:0] C_MAN  = 32'h0020_0000;
  localparam logic [31:0] C_AUTO = 32'h0040_0000;

  always #5 clk = ~clk;

  reload_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wrap_pulse(wrap_pulse)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_addr = 8'h40;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 8'h40; #1;
  endtask

  task automatic setup(input int p, input int s, input int n, input bit au);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'(p) << 8);
    wr(8'h04, 32'(s) << 16);
    wr(8'h3C, 32'(n));
    wr(8'h08, C_MAN | (au ? C_AUTO : 32'h0));
    wr(8'h08, au ? C_AUTO : 32'h0);
  endtask

  task automatic sweep_one(input int p, input int s, input int n, input bit au);
    int per, cyc;
    logic [31:0] v;
    per = (p + 1) * (2 << ((s > 3) ? 3 : s));
    setup(p, s, n, au);
    rd(8'h40, v);
    check("R4 manual load", v, 32'(n));
    wr(8'h08, C_RUN | (au ? C_AUTO : 32'h0));
    cyc = per * (n + 1) * 2 + 3;
    for (int k = 1; k <= cyc; k++) begin
      int t, ec;
      bit ep;
      step();
      t = k / per;
      if (au) ec = n - (t % (n + 1));
      else    ec = (t >= n) ? 0 : n - t;
      if (k % per != 0) ep = 1'b0;
      else if (au)      ep = (t % (n + 1)) == 0;
      else              ep = (t == n + 1);
      check("R3/R5/R6/R7 count", {16'h0, reg_rdata[15:0]}, 32'(ec));
      check("R8 pulse", {31'h0, wrap_pulse}, {31'h0, ep});
    end
  endtask

  initial begin
    int lim;
    lim = 0;
    while (lim < 200000) begin @(posedge clk); lim++; end
    errors++;
    $display("FAIL watchdog expired got=%0d exp=done", lim);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd(8'h00, v); check("R1 prescale reg", v, 32'h0);
    rd(8'h04, v); check("R1 divider reg", v, 32'h0);
    rd(8'h08, v); check("R1 control reg", v, 32'h0);
    rd(8'h3C, v); check("R1 buffer reg", v, 32'h0);
    rd(8'h40, v); check("R1 count", v, 32'h0);
    check("R1 pulse", {31'h0, wrap_pulse}, 32'h0);

    // R2 field positions and read-back
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 prescale field", v, 32'h0000_FF00);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 divider field", v, 32'h000F_0000);
    wr(8'h3C, 32'hFFFF_1234); rd(8'h3C, v); check("R2 buffer field", v, 32'h0000_1234);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R2 control bits", v, 32'h0070_0000);
    wr(8'h08, 32'h0);
    rd(8'h40, v); check("R2 count after manual", v, 32'h0000_1234);
    wr(8'h40, 32'h0000_0055); rd(8'h40, v); check("R2 observation read-only", v, 32'h0000_1234);

    // R3 R5 R6 R7 R8 sweep
    for (int p = 0; p < 3; p++)
      for (int si = 0; si < 5; si++)
        for (int ni = 0; ni < 3; ni++)
          for (int a = 0; a < 2; a++) begin
            int s, n;
            s = (si == 4) ? 5 : si;
            n = (ni == 2) ? 3 : ni;
            sweep_one(p, s, n, a[0]);
          end

    // R10 stop and restart
    setup(0, 0, 10, 1'b1);
    wr(8'h08, C_RUN | C_AUTO);
    repeat (6) step();
    rd(8'h40, v); check("R10 before stop", v, 32'd7);
    wr(8'h08, C_AUTO);
    repeat (10) step();
    rd(8'h40, v); check("R10 frozen", v, 32'd7);
    wr(8'h08, C_RUN | C_AUTO);
    step();
    rd(8'h40, v); check("R10 no tick one cycle after restart", v, 32'd7);
    step();
    rd(8'h40, v); check("R10 first tick after restart", v, 32'd6);

    // R9 buffer write on the reload edge
    setup(0, 0, 1, 1'b1);
    wr(8'h08, C_RUN | C_AUTO);
    repeat (3) step();
    wr(8'h3C, 32'd5);
    rd(8'h40, v); check("R9 old buffer on collision", v, 32'd1);
    check("R9 pulse on collision", {31'h0, wrap_pulse}, 32'h1);
    repeat (2) step();
    rd(8'h40, v); check("R9 count before next wrap", v, 32'd0);
    repeat (2) step();
    rd(8'h40, v); check("R9 new buffer at next wrap", v, 32'd5);
    check("R9 pulse at next wrap", {31'h0, wrap_pulse}, 32'h1);

    // R9 buffer write mid-count leaves count alone
    wr(8'h3C, 32'd9);
    rd(8'h40, v); check("R9 mid-count write ignored", v, 32'd5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule